// File: doc/BRIEF.md
# Register-Mapped Asynchronous Serial Port

This block is a byte-wide asynchronous serial port with a small register file on a simple synchronous bus. Software sets a 12-bit bit-rate divisor and a line-control byte while the port is disabled, and then enables it. A write to the data register queues a character for transmission. A read from the data register takes the oldest received character. Each received character carries its own three error flags. These flags become readable in a status register at the moment the character is taken.

Each direction has a 16-entry queue. Clearing one line-control bit shrinks both queues to a single entry. The transmitter serialises 5 to 8 data bits, LSB first. It can add an even or odd parity bit and one or two stop bits, and a break bit drives the line low. The receiver oversamples the line 16 times per bit. Two interrupt requests signal that receive data is waiting and that the transmit queue has room.

Register offsets: 0 data, 1 receive status, 2 line control, 3 divisor low byte, 4 divisor upper nibble (bits 3:0), 5 control (bit 0 enable), 6 flags.

Top module: `sio_port`

## Requirements
- R1: After reset, the flags register reads 0x10, the status register reads 0, both interrupt requests are low, and `txd` is high.
- R2: One bit lasts 16 × (divisor + 1) clock cycles. The divisor is formed from register 3 (bits 7:0) and bits 3:0 of register 4 (bits 11:8).
- R3: A transmitted frame is one low start bit, then the data bits LSB first, then the stop bits high. Line control bits 6:5 select the word length: 00 = 5, 01 = 6, 10 = 7, 11 = 8 bits. Bit 3 set selects two stop bits. Data bits above the word length are not sent.
- R4: Line control bit 1 adds a parity bit after the data bits. Bit 2 set makes the parity even (data ones plus parity is an even count). Bit 2 clear makes it odd.
- R5: While line control bit 0 is set, `txd` is held low.
- R6: A received frame is stored in the receive queue. The flags register bit 4 reads 1 exactly when that queue is empty. Reading register 0 returns the oldest character and removes it.
- R7: The status register holds the flags of the character most recently read. Bit 0 is a framing error (stop bit sampled low). Bit 1 is a parity mismatch.
- R8: When a frame completes while the receive queue is full (16 entries), the frame is discarded and status bit 2 (overrun) is set on the newest stored character.
- R9: The transmit queue holds 16 characters. Flags bit 5 reads 1 when it is full. A data write while it is full is dropped.
- R10: A read of register 0 while the receive queue is empty returns the last character read and leaves the status register unchanged.
- R11: With line control bit 4 clear, each queue holds one character. Full, drop and overrun then apply at one entry.
- R12: With control bit 0 clear, nothing is transmitted or received and both interrupt requests are low. Writes still fill the transmit queue.
- R13: `irq_rx` is high while enabled and the receive queue is not empty. `irq_tx` is high while enabled and the transmit queue is not full.
- R14: Flags bit 3 reads 1 while the transmit queue holds data or a frame is being shifted out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the access cycle |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| irq_rx | output | 1 | Receive data waiting |
| irq_tx | output | 1 | Transmit queue has room |

## Verification
The bench builds the port with its default queue depth of 16 and 16× oversampling. At that depth it can fill the receive queue and push one more frame to produce an overrun, and it can fill the transmit queue and check that a seventeenth write is dropped. Most scenarios use divisor 0, so a bit lasts 16 cycles and whole frames fit in a few hundred cycles. One scenario sets divisor 0x102, which puts a nonzero value in the upper nibble register, and measures the start bit at 4144 cycles. The one-entry queue mode is run on both the transmit and receive paths.

// File: rtl/sio_pkg.sv
package sio_pkg;
    localparam int DIV_W  = 12;
    localparam int BYTE_W = 8;
    localparam int STAT_W = 3;

    localparam logic [2:0] A_DATA  = 3'd0;
    localparam logic [2:0] A_STAT  = 3'd1;
    localparam logic [2:0] A_LCR   = 3'd2;
    localparam logic [2:0] A_DIVLO = 3'd3;
    localparam logic [2:0] A_DIVHI = 3'd4;
    localparam logic [2:0] A_CTRL  = 3'd5;
    localparam logic [2:0] A_FLAGS = 3'd6;

    typedef struct packed {
        logic       spare;
        logic [1:0] wlen;
        logic       fifo_en;
        logic       two_stop;
        logic       even;
        logic       par_en;
        logic       brk;
    } lcr_t;

    typedef enum logic [2:0] {L_IDLE, L_START, L_DATA, L_PAR, L_STOP} line_st_e;

    // index of the final data bit for a word-length code (4..7)
    function automatic logic [2:0] last_bit(input logic [1:0] wlen);
        return 3'd4 + {1'b0, wlen};
    endfunction

    function automatic logic [7:0] word_mask(input logic [1:0] wlen);
        return 8'hFF >> (2'd3 - wlen);
    endfunction

    function automatic logic par_of(input logic [7:0] d, input logic even);
        return even ? ^d : ~^d;
    endfunction
endpackage

// File: rtl/sio_fifo.sv
module sio_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [W-1:0]  wdata,
    input  logic [W-1:0]  or_last,
    output logic [W-1:0]  rdata,
    output logic [CW-1:0] count
);
    // DEPTH must be a power of two: pointers wrap by overflow.
    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } ptr_s;

    ptr_s ptr_d, ptr_q;
    logic [W-1:0] mem [DEPTH];

    always_comb begin
        ptr_d = ptr_q;
        if (push) ptr_d.wp = ptr_q.wp + 1'b1;
        if (pop)  ptr_d.rp = ptr_q.rp + 1'b1;
        ptr_d.cnt = ptr_q.cnt + CW'(push) - CW'(pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    always_ff @(posedge clk) begin
        if (push) mem[ptr_q.wp] <= wdata;
        if ((|or_last) && ptr_q.cnt != '0)
            mem[ptr_q.wp - 1'b1] <= mem[ptr_q.wp - 1'b1] | or_last;
    end

    assign rdata = mem[ptr_q.rp];
    assign count = ptr_q.cnt;
endmodule

// File: rtl/sio_baud.sv
module sio_baud #(
    parameter int DW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [DW-1:0] div,
    output logic          tick
);
    logic [DW-1:0] cnt_d, cnt_q;

    assign tick = en && (cnt_q == div);

    always_comb begin
        cnt_d = (!en || tick) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/sio_tx.sv
module sio_tx
    import sio_pkg::*;
#(
    parameter int OVS = 16,
    localparam int TW = $clog2(OVS)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       tick,
    input  logic [1:0] wlen,
    input  logic       par_en,
    input  logic       even,
    input  logic       two_stop,
    input  logic       brk,
    input  logic       have,
    input  logic [7:0] din,
    output logic       take,
    output logic       busy,
    output logic       txd
);
    localparam logic [TW-1:0] TLAST = TW'(OVS - 1);

    typedef struct packed {
        line_st_e      st;
        logic [TW-1:0] tc;
        logic [2:0]    bi;
        logic [7:0]    sh;
        logic          par;
        logic          second;
    } tx_s;

    tx_s tx_d, tx_q;
    logic bit_end;
    logic line;

    always_comb begin
        tx_d    = tx_q;
        take    = 1'b0;
        bit_end = tick && (tx_q.tc == TLAST);
        if (tick && tx_q.st != L_IDLE)
            tx_d.tc = bit_end ? '0 : tx_q.tc + 1'b1;
        case (tx_q.st)
            L_IDLE: begin
                if (have && tick) begin
                    take      = 1'b1;
                    tx_d.sh   = din & word_mask(wlen);
                    tx_d.par  = par_of(din & word_mask(wlen), even);
                    tx_d.st   = L_START;
                    tx_d.tc   = '0;
                end
            end
            L_START: begin
                if (bit_end) begin
                    tx_d.st = L_DATA;
                    tx_d.bi = '0;
                end
            end
            L_DATA: begin
                if (bit_end) begin
                    tx_d.sh = tx_q.sh >> 1;
                    if (tx_q.bi == last_bit(wlen)) begin
                        tx_d.st     = par_en ? L_PAR : L_STOP;
                        tx_d.second = 1'b0;
                    end else begin
                        tx_d.bi = tx_q.bi + 1'b1;
                    end
                end
            end
            L_PAR: begin
                if (bit_end) begin
                    tx_d.st     = L_STOP;
                    tx_d.second = 1'b0;
                end
            end
            L_STOP: begin
                if (bit_end) begin
                    if (two_stop && !tx_q.second) tx_d.second = 1'b1;
                    else                          tx_d.st     = L_IDLE;
                end
            end
            default: tx_d.st = L_IDLE;
        endcase
        if (!en) begin
            tx_d.st = L_IDLE;
            tx_d.tc = '0;
            take    = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tx_q <= '{st: L_IDLE, default: '0};
        else        tx_q <= tx_d;
    end

    always_comb begin
        case (tx_q.st)
            L_START: line = 1'b0;
            L_DATA:  line = tx_q.sh[0];
            L_PAR:   line = tx_q.par;
            default: line = 1'b1;
        endcase
    end

    assign txd  = brk ? 1'b0 : line;
    assign busy = (tx_q.st != L_IDLE);
endmodule

// File: rtl/sio_rx.sv
module sio_rx
    import sio_pkg::*;
#(
    parameter int OVS = 16,
    localparam int TW = $clog2(OVS)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       tick,
    input  logic [1:0] wlen,
    input  logic       par_en,
    input  logic       even,
    input  logic       rxd,
    output logic       done,
    output logic [7:0] dout,
    output logic       ferr,
    output logic       perr
);
    localparam logic [TW-1:0] TLAST = TW'(OVS - 1);
    localparam logic [TW-1:0] THALF = TW'(OVS / 2 - 1);

    typedef struct packed {
        line_st_e      st;
        logic [TW-1:0] tc;
        logic [2:0]    bi;
        logic [7:0]    sh;
        logic          perr;
        logic          ferr;
        logic          done;
    } rx_s;

    rx_s rx_d, rx_q;

    always_comb begin
        rx_d      = rx_q;
        rx_d.done = 1'b0;
        case (rx_q.st)
            L_IDLE: begin
                if (tick && !rxd) begin
                    rx_d.st = L_START;
                    rx_d.tc = '0;
                end
            end
            L_START: begin
                if (tick) begin
                    if (rx_q.tc == THALF) begin
                        if (!rxd) begin
                            rx_d.st   = L_DATA;
                            rx_d.tc   = '0;
                            rx_d.bi   = '0;
                            rx_d.sh   = '0;
                            rx_d.perr = 1'b0;
                        end else begin
                            rx_d.st = L_IDLE;
                        end
                    end else begin
                        rx_d.tc = rx_q.tc + 1'b1;
                    end
                end
            end
            L_DATA: begin
                if (tick) begin
                    if (rx_q.tc == TLAST) begin
                        rx_d.tc           = '0;
                        rx_d.sh[rx_q.bi]  = rxd;
                        if (rx_q.bi == last_bit(wlen)) rx_d.st = par_en ? L_PAR : L_STOP;
                        else                           rx_d.bi = rx_q.bi + 1'b1;
                    end else begin
                        rx_d.tc = rx_q.tc + 1'b1;
                    end
                end
            end
            L_PAR: begin
                if (tick) begin
                    if (rx_q.tc == TLAST) begin
                        rx_d.tc   = '0;
                        rx_d.perr = (rxd != par_of(rx_q.sh, even));
                        rx_d.st   = L_STOP;
                    end else begin
                        rx_d.tc = rx_q.tc + 1'b1;
                    end
                end
            end
            L_STOP: begin
                if (tick) begin
                    if (rx_q.tc == TLAST) begin
                        rx_d.ferr = !rxd;
                        rx_d.done = 1'b1;
                        rx_d.st   = L_IDLE;
                    end else begin
                        rx_d.tc = rx_q.tc + 1'b1;
                    end
                end
            end
            default: rx_d.st = L_IDLE;
        endcase
        if (!en) begin
            rx_d.st   = L_IDLE;
            rx_d.done = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rx_q <= '{st: L_IDLE, default: '0};
        else        rx_q <= rx_d;
    end

    assign done = rx_q.done;
    assign dout = rx_q.sh;
    assign ferr = rx_q.ferr;
    assign perr = rx_q.perr;
endmodule

// File: rtl/sio_port.sv
module sio_port
    import sio_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int OVS   = 16,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int EW   = STAT_W + BYTE_W
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_sel,
    input  logic       bus_wr,
    input  logic [2:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       rxd,
    output logic       txd,
    output logic       irq_rx,
    output logic       irq_tx
);
    typedef struct packed {
        logic              en;
        lcr_t              lcr;
        logic [DIV_W-1:0]  div;
        logic [BYTE_W-1:0] last_d;
        logic [STAT_W-1:0] last_s;
        logic              sy1;
        logic              sy2;
    } regs_s;

    regs_s reg_d, reg_q;

    logic          tick;
    logic          tx_take, tx_busy;
    logic [EW-1:0] rx_head;
    logic [7:0]    tx_head;
    logic [CW-1:0] rx_cnt, tx_cnt, cap;
    logic          rx_empty, rx_full, tx_empty, tx_full;
    logic          rx_done, rx_ferr, rx_perr;
    logic [7:0]    rx_byte;
    logic          wr_data, rd_data, tx_push, rx_pop, rx_push;
    logic [EW-1:0] rx_mark;

    assign cap      = reg_q.lcr.fifo_en ? CW'(DEPTH) : CW'(1);
    assign rx_empty = (rx_cnt == '0);
    assign tx_empty = (tx_cnt == '0);
    assign rx_full  = (rx_cnt >= cap);
    assign tx_full  = (tx_cnt >= cap);

    assign wr_data = bus_sel && bus_wr && (bus_addr == A_DATA);
    assign rd_data = bus_sel && !bus_wr && (bus_addr == A_DATA);
    assign tx_push = wr_data && !tx_full;
    assign rx_pop  = rd_data && !rx_empty;
    assign rx_push = rx_done && !rx_full;
    assign rx_mark = (rx_done && rx_full) ? {3'b100, 8'h00} : '0;

    always_comb begin
        reg_d     = reg_q;
        reg_d.sy1 = rxd;
        reg_d.sy2 = reg_q.sy1;
        if (bus_sel && bus_wr) begin
            case (bus_addr)
                A_LCR:   reg_d.lcr       = lcr_t'(bus_wdata);
                A_DIVLO: reg_d.div[7:0]  = bus_wdata;
                A_DIVHI: reg_d.div[11:8] = bus_wdata[3:0];
                A_CTRL:  reg_d.en        = bus_wdata[0];
                default: ;
            endcase
        end
        if (rx_pop) begin
            reg_d.last_d = rx_head[BYTE_W-1:0];
            reg_d.last_s = rx_head[EW-1:BYTE_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) reg_q <= '{sy1: 1'b1, sy2: 1'b1, default: '0};
        else        reg_q <= reg_d;
    end

    always_comb begin
        case (bus_addr)
            A_DATA:  bus_rdata = rx_empty ? reg_q.last_d : rx_head[BYTE_W-1:0];
            A_STAT:  bus_rdata = {5'b0, reg_q.last_s};
            A_LCR:   bus_rdata = reg_q.lcr;
            A_DIVLO: bus_rdata = reg_q.div[7:0];
            A_DIVHI: bus_rdata = {4'b0, reg_q.div[11:8]};
            A_CTRL:  bus_rdata = {7'b0, reg_q.en};
            A_FLAGS: bus_rdata = {2'b00, tx_full, rx_empty, tx_busy || !tx_empty, 3'b000};
            default: bus_rdata = 8'h00;
        endcase
    end

    assign irq_rx = reg_q.en && !rx_empty;
    assign irq_tx = reg_q.en && !tx_full;

    sio_baud #(.DW(DIV_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .en(reg_q.en), .div(reg_q.div), .tick(tick)
    );

    sio_fifo #(.W(BYTE_W), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .push(tx_push), .pop(tx_take),
        .wdata(bus_wdata), .or_last('0), .rdata(tx_head), .count(tx_cnt)
    );

    sio_fifo #(.W(EW), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .pop(rx_pop),
        .wdata({1'b0, rx_perr, rx_ferr, rx_byte}), .or_last(rx_mark),
        .rdata(rx_head), .count(rx_cnt)
    );

    sio_tx #(.OVS(OVS)) u_tx (
        .clk(clk), .rst_n(rst_n), .en(reg_q.en), .tick(tick),
        .wlen(reg_q.lcr.wlen), .par_en(reg_q.lcr.par_en), .even(reg_q.lcr.even),
        .two_stop(reg_q.lcr.two_stop), .brk(reg_q.lcr.brk),
        .have(!tx_empty), .din(tx_head), .take(tx_take), .busy(tx_busy), .txd(txd)
    );

    sio_rx #(.OVS(OVS)) u_rx (
        .clk(clk), .rst_n(rst_n), .en(reg_q.en), .tick(tick),
        .wlen(reg_q.lcr.wlen), .par_en(reg_q.lcr.par_en), .even(reg_q.lcr.even),
        .rxd(reg_q.sy2), .done(rx_done), .dout(rx_byte), .ferr(rx_ferr), .perr(rx_perr)
    );
endmodule

// File: rtl/sio_port_chk.sv
module sio_port_chk
    import sio_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_sel,
    input logic          bus_wr,
    input logic [2:0]    bus_addr,
    input logic          txd,
    input logic          irq_rx,
    input logic          irq_tx,
    input logic          en,
    input logic          brk,
    input logic [CW-1:0] rx_cnt,
    input logic [CW-1:0] tx_cnt,
    input logic          tx_full,
    input logic          tx_take,
    input logic [2:0]    last_s
);
    localparam logic [CW-1:0] DEP = CW'(DEPTH);

    a_r5_break_low: assert property (@(posedge clk) disable iff (!rst_n)
        brk |-> !txd);

    a_r12_disabled_line_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !brk) |-> txd);

    a_r9_tx_bound: assert property (@(posedge clk) disable iff (!rst_n)
        tx_cnt <= DEP);

    a_r8_rx_bound: assert property (@(posedge clk) disable iff (!rst_n)
        rx_cnt <= DEP);

    a_r9_drop_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == A_DATA && tx_full && !tx_take)
        |=> tx_cnt == $past(tx_cnt));

    a_r10_empty_read_keeps_status: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == A_DATA && rx_cnt == '0) |=> $stable(last_s));

    a_r13_rx_irq_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        irq_rx |-> rx_cnt != '0);

    a_r13_tx_irq_needs_room: assert property (@(posedge clk) disable iff (!rst_n)
        irq_tx |-> tx_cnt < DEP);
endmodule

bind sio_port sio_port_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .txd(txd), .irq_rx(irq_rx), .irq_tx(irq_tx), .en(reg_q.en), .brk(reg_q.lcr.brk),
    .rx_cnt(rx_cnt), .tx_cnt(tx_cnt), .tx_full(tx_full), .tx_take(tx_take),
    .last_s(reg_q.last_s)
);

// File: tb/sio_port_test.sv
`timescale 1ns/1ps
module sio_port_test;
    localparam logic [2:0] A_DATA = 0, A_STAT = 1, A_LCR = 2, A_DLO = 3, A_DHI = 4,
                           A_CTRL = 5, A_FLAGS = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_wr = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       rxd = 1'b1;
    logic       txd, irq_rx, irq_tx;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    sio_port uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rxd(rxd), .txd(txd), .irq_rx(irq_rx), .irq_tx(irq_tx)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic bwr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic brd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic setup(input logic [7:0] lcr, input logic [11:0] div);
        bwr(A_CTRL, 8'h00);
        bwr(A_DLO, div[7:0]);
        bwr(A_DHI, {4'h0, div[11:8]});
        bwr(A_LCR, lcr);
        bwr(A_CTRL, 8'h01);
    endtask

    function automatic logic [7:0] msk(input logic [7:0] d, input int nb);
        return d & (8'hFF >> (8 - nb));
    endfunction

    task automatic rx_send(input logic [7:0] d, input int nb, input bit pen, input bit even,
                           input bit bad_par, input bit stop_v, input int bc);
        logic p;
        p = (even ? ^msk(d, nb) : ~^msk(d, nb)) ^ bad_par;
        rxd = 1'b0; repeat (bc) @(negedge clk);
        for (int i = 0; i < nb; i++) begin
            rxd = d[i]; repeat (bc) @(negedge clk);
        end
        if (pen) begin
            rxd = p; repeat (bc) @(negedge clk);
        end
        rxd = stop_v; repeat (bc) @(negedge clk);
        rxd = 1'b1; repeat (bc) @(negedge clk);
    endtask

    task automatic tx_grab(input int nb, input bit pen, input bit two, input int bc,
                           output logic [7:0] d, output logic p, output logic s1,
                           output logic s2, output bit ok);
        int w;
        w = 0; ok = 1'b1; d = '0; p = 1'b0; s1 = 1'b0; s2 = 1'b1;
        while (txd !== 1'b0 && w < 60000) begin
            @(negedge clk); w++;
        end
        if (w >= 60000) begin
            ok = 1'b0;
            return;
        end
        repeat (bc / 2) @(negedge clk);
        for (int i = 0; i < nb; i++) begin
            repeat (bc) @(negedge clk);
            d[i] = txd;
        end
        if (pen) begin
            repeat (bc) @(negedge clk);
            p = txd;
        end
        repeat (bc) @(negedge clk);
        s1 = txd;
        if (two) begin
            repeat (bc) @(negedge clk);
            s2 = txd;
        end
    endtask

    task automatic wait_idle();
        logic [7:0] f;
        for (int i = 0; i < 3000; i++) begin
            brd(A_FLAGS, f);
            if (!f[3]) return;
        end
    endtask

    task automatic t_reset();
        logic [7:0] v;
        brd(A_FLAGS, v); chk("R1 flags after reset", v, 8'h10);
        brd(A_STAT, v);  chk("R1 status after reset", v, 0);
        chk("R1 irq_rx after reset", irq_rx, 0);
        chk("R12 irq_tx low while disabled", irq_tx, 0);
        chk("R1 txd idle high", txd, 1);
    endtask

    task automatic t_tx_formats();
        logic [7:0] d, f;
        logic p, s1, s2;
        bit ok;
        // 8N1
        setup(8'h70, 12'h000);
        chk("R13 irq_tx with room", irq_tx, 1);
        bwr(A_DATA, 8'hA5);
        brd(A_FLAGS, f); chk("R14 busy while sending", f[3], 1);
        tx_grab(8, 0, 0, 16, d, p, s1, s2, ok);
        chk("R3 8N1 frame found", ok, 1);
        chk("R3 8N1 data", d, 8'hA5);
        chk("R3 8N1 stop", s1, 1);
        wait_idle();
        brd(A_FLAGS, f); chk("R14 idle after frame", f, 8'h10);
        // 7 bits, even parity, two stops
        setup(8'h5E, 12'h000);
        bwr(A_DATA, 8'h3B);
        tx_grab(7, 1, 1, 16, d, p, s1, s2, ok);
        chk("R3 7E2 data", d, 8'h3B);
        chk("R4 even parity bit", p, 1);
        chk("R3 first stop", s1, 1);
        chk("R3 second stop", s2, 1);
        wait_idle();
        // 5 bits, odd parity
        setup(8'h12, 12'h000);
        bwr(A_DATA, 8'hE6);
        tx_grab(5, 1, 0, 16, d, p, s1, s2, ok);
        chk("R3 5-bit word truncated", d, 8'h06);
        chk("R4 odd parity bit", p, 1);
        chk("R3 5O1 stop", s1, 1);
        wait_idle();
    endtask

    task automatic t_divisor();
        logic [7:0] v;
        int n;
        setup(8'h70, 12'h102);
        brd(A_DHI, v); chk("R2 divisor upper nibble readback", v, 8'h01);
        bwr(A_DATA, 8'hFF);
        n = 0;
        while (txd !== 1'b0 && n < 20000) begin @(negedge clk); n++; end
        n = 0;
        while (txd === 1'b0 && n < 20000) begin @(negedge clk); n++; end
        chk("R2 start bit length for divisor 0x102", n, 16 * 259);
        bwr(A_CTRL, 8'h00);
    endtask

    task automatic t_break();
        setup(8'h71, 12'h000);
        repeat (2) @(negedge clk);
        chk("R5 break holds txd low", txd, 0);
        bwr(A_LCR, 8'h70);
        @(negedge clk);
        chk("R5 break released", txd, 1);
    endtask

    task automatic t_rx_basic();
        logic [7:0] v;
        setup(8'h70, 12'h000);
        rx_send(8'h5A, 8, 0, 0, 0, 1, 16);
        brd(A_FLAGS, v); chk("R6 rx not empty after frame", v[4], 0);
        chk("R13 irq_rx with data", irq_rx, 1);
        brd(A_DATA, v); chk("R6 received byte", v, 8'h5A);
        brd(A_STAT, v); chk("R7 clean status", v, 0);
        brd(A_FLAGS, v); chk("R6 rx empty after read", v[4], 1);
        chk("R13 irq_rx cleared", irq_rx, 0);
    endtask

    task automatic t_rx_errors();
        logic [7:0] v;
        setup(8'h76, 12'h000);
        rx_send(8'h33, 8, 1, 1, 1, 1, 16);
        rx_send(8'h44, 8, 1, 1, 0, 0, 16);
        brd(A_DATA, v); chk("R7 data with parity error", v, 8'h33);
        brd(A_STAT, v); chk("R7 parity error bit", v, 8'h02);
        brd(A_DATA, v); chk("R7 data with framing error", v, 8'h44);
        brd(A_STAT, v); chk("R7 framing error bit", v, 8'h01);
    endtask

    task automatic t_rx_overrun();
        logic [7:0] v;
        int bad;
        setup(8'h70, 12'h000);
        for (int i = 0; i < 17; i++) rx_send(8'h80 + 8'(i), 8, 0, 0, 0, 1, 16);
        bad = 0;
        for (int i = 0; i < 16; i++) begin
            brd(A_DATA, v);
            if (v != 8'h80 + 8'(i)) bad++;
            brd(A_STAT, v);
            if (v != ((i == 15) ? 8'h04 : 8'h00)) bad++;
        end
        chk("R8 sixteen stored, overrun on newest", bad, 0);
        brd(A_FLAGS, v); chk("R8 extra frame discarded", v[4], 1);
        brd(A_DATA, v); chk("R10 empty read repeats last byte", v, 8'h8F);
        brd(A_STAT, v); chk("R10 empty read keeps status", v, 8'h04);
    endtask

    task automatic t_tx_full();
        logic [7:0] v, d;
        logic p, s1, s2;
        bit ok;
        int bad;
        setup(8'h70, 12'h000);
        bwr(A_CTRL, 8'h00);
        for (int i = 0; i < 17; i++) bwr(A_DATA, 8'h40 + 8'(i));
        brd(A_FLAGS, v); chk("R9 tx full flag", v, 8'h38);
        chk("R12 irq_tx gated off", irq_tx, 0);
        rx_send(8'h11, 8, 0, 0, 0, 1, 16);
        brd(A_FLAGS, v); chk("R12 no reception while disabled", v[4], 1);
        chk("R12 txd idle while disabled", txd, 1);
        bwr(A_CTRL, 8'h01);
        bad = 0;
        for (int i = 0; i < 16; i++) begin
            tx_grab(8, 0, 0, 16, d, p, s1, s2, ok);
            if (!ok || d != 8'h40 + 8'(i) || !s1) bad++;
        end
        chk("R9 sixteen queued bytes sent in order", bad, 0);
        wait_idle();
        brd(A_FLAGS, v); chk("R9 seventeenth write dropped", v, 8'h10);
    endtask

    task automatic t_fifo_off();
        logic [7:0] v, d;
        logic p, s1, s2;
        bit ok;
        setup(8'h60, 12'h000);
        bwr(A_CTRL, 8'h00);
        bwr(A_DATA, 8'hC1);
        brd(A_FLAGS, v); chk("R11 full at one entry", v[5], 1);
        bwr(A_DATA, 8'hC2);
        bwr(A_CTRL, 8'h01);
        tx_grab(8, 0, 0, 16, d, p, s1, s2, ok);
        chk("R11 first byte sent", d, 8'hC1);
        wait_idle();
        brd(A_FLAGS, v); chk("R11 second write dropped", v, 8'h10);
        rx_send(8'h21, 8, 0, 0, 0, 1, 16);
        rx_send(8'h22, 8, 0, 0, 0, 1, 16);
        brd(A_DATA, v); chk("R11 one-entry rx keeps first", v, 8'h21);
        brd(A_STAT, v); chk("R11 overrun at one entry", v, 8'h04);
        brd(A_FLAGS, v); chk("R11 rx empty after one read", v[4], 1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_tx_formats();
        t_divisor();
        t_break();
        t_rx_basic();
        t_rx_errors();
        t_rx_overrun();
        t_tx_full();
        t_fifo_off();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule